// File: doc/BRIEF.md
# Branch Trace History Queue

This block keeps a short history of program-flow changes for debug. It watches the stream of fetch addresses and a branch-taken strobe. For every branch it records one entry that holds two 28-bit addresses: the source, which is the last address fetched before the branch, and the destination, which is the first address fetched after it. Entries enter an eight-slot shift queue. Slot 0 always holds the newest entry, and every new entry pushes the older ones one slot deeper.

Debug software reads the history back through two 32-bit read-only words. A select bit chooses between them, and a read strobe starts the read. A read always returns the newest entry that has not yet been read. Reading the destination word consumes that entry by clearing its valid flag, so the next pair of reads returns the next older branch. Both resets clear the valid flags and leave the stored addresses as they are. The read port has no back-pressure: the data is presented for exactly one cycle, marked by `rd_ack`. The fetch input is accepted on every cycle in which `fetch_valid` is high and never stalls the fetch stream.

Top module: `flow_trace_hist`

## Requirements
- R1: The queue holds DEPTH (8) entries. Each captured branch shifts every entry one slot deeper and inserts the new entry as the newest. Reads return entries newest first.
- R2: With `rd_sel`=1 (destination word), `rd_data` bit 31 is the entry's valid flag, bits 30..28 are 0, and bits 27..0 are the destination address.
- R3: With `rd_sel`=0 (source word), bits 27..0 are the source address, bit 31 is the same entry's valid flag, and bits 30..28 are 0. A source read does not consume the entry.
- R4: The source is the last fetch accepted before the strobe cycle; a fetch in the strobe cycle itself counts as before the branch. The destination is the first fetch accepted in a later cycle, and the entry is inserted in that cycle.
- R5: A destination read clears the valid flag of the entry it returned, so the next read returns the next older valid entry.
- R6: When an insertion and a destination read fall in the same cycle, the read returns and consumes the entry that was newest before the insertion, and the new entry stays valid.
- R7: A branch captured while all DEPTH entries are valid drops the oldest entry. Only the newest DEPTH branches can then be read.
- R8: The asynchronous power-on reset `rst_n` and the synchronous manual reset `mrst` both clear every valid flag and any branch still waiting for its destination.
- R9: Read data is registered. `rd_ack` and `rd_data` appear in the cycle after `rd_en`. When no entry is valid, `rd_data` is all zero.
- R10: A strobe that arrives while a branch is still waiting for its destination discards the waiting capture and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mrst | input | 1 | Synchronous manual reset, active high |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| br_taken | input | 1 | Branch-taken strobe, one cycle |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 = source word, 1 = destination word |
| rd_ack | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DATA_W | Read word |

## Verification
The hardest case to reach from the ports is a queue insertion that lands in the same cycle as a destination read. Insertion does not happen on the strobe; it happens on the next fetch. The bench therefore issues a fetch, then a strobe, and then drives the destination fetch and the read strobe together on one edge. The waiting-capture restart is reached in a similar way: a second strobe is driven together with a fetch while the first branch still has no destination. Filling the queue past DEPTH entries and then draining it with destination reads shows that exactly the oldest entry was lost.

// File: rtl/fth_pkg.sv
package fth_pkg;
  typedef enum logic {
    SEL_SRC = 1'b0,
    SEL_DST = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/fth_capture.sv
module fth_capture #(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              br_taken,
  output logic              push,
  output logic [ADDR_W-1:0] push_src,
  output logic [ADDR_W-1:0] push_dst
);
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] src_q;
  logic              wait_q;

  // Address registers carry no reset; their contents are don't-care until used.
  always_ff @(posedge clk) begin
    if (fetch_valid) last_q <= fetch_addr;
    if (br_taken)    src_q  <= fetch_valid ? fetch_addr : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_q <= 1'b0;
    else if (mrst)             wait_q <= 1'b0;
    else if (br_taken)         wait_q <= 1'b1;
    else if (fetch_valid)      wait_q <= 1'b0;
  end

  assign push     = wait_q && fetch_valid && !br_taken && !mrst;
  assign push_src = src_q;
  assign push_dst = fetch_addr;
endmodule

// File: rtl/fth_store.sv
module fth_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_src,
  input  logic [ADDR_W-1:0] push_dst,
  input  logic [DEPTH-1:0]  clr,
  output logic [DEPTH-1:0]  vld,
  output logic [ADDR_W-1:0] src [DEPTH],
  output logic [ADDR_W-1:0] dst [DEPTH]
);
  logic [DEPTH-1:0] vld_nxt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (push) begin
          src[i] <= push_src;
          dst[i] <= push_dst;
        end
      end
      assign vld_nxt[i] = push ? 1'b1 : (vld[i] & ~clr[i]);
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (push) begin
          src[i] <= src[i-1];
          dst[i] <= dst[i-1];
        end
      end
      assign vld_nxt[i] = push ? (vld[i-1] & ~clr[i-1]) : (vld[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vld <= '0;
    else if (mrst) vld <= '0;
    else           vld <= vld_nxt;
  end
endmodule

// File: rtl/fth_readout.sv
module fth_readout
  import fth_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [DEPTH-1:0]  vld,
  input  logic [ADDR_W-1:0] src [DEPTH],
  input  logic [ADDR_W-1:0] dst [DEPTH],
  output logic [DEPTH-1:0]  clr,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PAD_W = DATA_W - 1 - ADDR_W;

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] word;
  logic             is_dst;

  assign is_dst = (rd_sel == SEL_DST);

  // Lowest valid slot is the newest unread entry.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign clr  = (rd_en && is_dst && hit && !mrst) ? (DEPTH'(1) << idx) : '0;
  assign word = hit ? {1'b1, {PAD_W{1'b0}}, (is_dst ? dst[idx] : src[idx])} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_ack <= 1'b0;
    else if (mrst) rd_ack <= 1'b0;
    else           rd_ack <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= word;
  end
endmodule

// File: rtl/flow_trace_hist.sv
module flow_trace_hist #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              br_taken,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data
);
  logic              push;
  logic [ADDR_W-1:0] push_src;
  logic [ADDR_W-1:0] push_dst;
  logic [DEPTH-1:0]  slot_vld;
  logic [DEPTH-1:0]  slot_clr;
  logic [ADDR_W-1:0] slot_src [DEPTH];
  logic [ADDR_W-1:0] slot_dst [DEPTH];

  fth_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .mrst(mrst),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .br_taken(br_taken),
    .push(push), .push_src(push_src), .push_dst(push_dst)
  );

  fth_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .mrst(mrst),
    .push(push), .push_src(push_src), .push_dst(push_dst),
    .clr(slot_clr), .vld(slot_vld), .src(slot_src), .dst(slot_dst)
  );

  fth_readout #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .mrst(mrst),
    .rd_en(rd_en), .rd_sel(rd_sel),
    .vld(slot_vld), .src(slot_src), .dst(slot_dst),
    .clr(slot_clr), .rd_ack(rd_ack), .rd_data(rd_data)
  );
endmodule

// File: rtl/fth_checker.sv
module fth_checker #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mrst,
  input logic              rd_en,
  input logic              rd_sel,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rd_data,
  input logic              push,
  input logic [DEPTH-1:0]  vld
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    rd_en |=> rd_ack); // R9
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    !rd_en |=> !rd_ack); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> (rd_data[30:28] == 3'b000)); // R2
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !rd_data[DATA_W-1]) |-> (rd_data == '0)); // R9
  AST_MRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (vld == '0)); // R8
  AST_PUSH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    push |=> vld[0]); // R1
  AST_CONSUME_ONE: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    (rd_en && rd_sel && !push && (vld != '0)) |=>
      ($countones(vld) == $countones($past(vld)) - 1)); // R5
  AST_SRC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    (!push && !(rd_en && rd_sel)) |=> $stable(vld)); // R3
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    (push && (&vld) && !(rd_en && rd_sel)) |=> (&vld)); // R7
endmodule

bind flow_trace_hist fth_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mrst(mrst), .rd_en(rd_en), .rd_sel(rd_sel),
  .rd_ack(rd_ack), .rd_data(rd_data), .push(push), .vld(slot_vld)
);

// File: tb/flow_trace_hist_test.sv
`timescale 1ns/1ps
module flow_trace_hist_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrst = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [27:0] fetch_addr = '0;
  logic        br_taken = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic        rd_ack;
  logic [31:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [27:0] m_src [8];
  logic [27:0] m_dst [8];
  bit          m_v   [8];

  always #4 clk = ~clk;

  flow_trace_hist uut (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .br_taken(br_taken), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit fv, input logic [27:0] fa, input bit br,
                     input bit re, input bit rs);
    @(negedge clk);
    fetch_valid = fv; fetch_addr = fa; br_taken = br; rd_en = re; rd_sel = rs;
    @(posedge clk);
    #1;
    @(negedge clk);
    fetch_valid = 0; br_taken = 0; rd_en = 0;
  endtask

  task automatic m_clear();
    for (int i = 0; i < 8; i++) m_v[i] = 0;
  endtask

  task automatic m_push(input logic [27:0] s, input logic [27:0] d);
    for (int i = 7; i > 0; i--) begin
      m_src[i] = m_src[i-1]; m_dst[i] = m_dst[i-1]; m_v[i] = m_v[i-1];
    end
    m_src[0] = s; m_dst[0] = d; m_v[0] = 1;
  endtask

  function automatic int m_top();
    for (int i = 0; i < 8; i++) if (m_v[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] m_word(input bit sel);
    int k = m_top();
    if (k < 0) return 32'h0;
    return {1'b1, 3'b000, (sel ? m_dst[k] : m_src[k])};
  endfunction

  task automatic rd(input bit sel, input string req);
    logic [31:0] exp = m_word(sel);
    int k = m_top();
    @(negedge clk);
    rd_en = 1; rd_sel = sel;
    @(posedge clk);
    #1;
    chk({req, " R9 ack"}, {31'b0, rd_ack}, 32'h1);
    chk(req, rd_data, exp);
    if (sel && k >= 0) m_v[k] = 0;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic branch(input logic [27:0] s, input logic [27:0] d);
    cyc(1, s, 0, 0, 0);
    cyc(0, '0, 1, 0, 0);
    cyc(0, '0, 0, 0, 0);
    cyc(1, d, 0, 0, 0);
    m_push(s, d);
  endtask

  task automatic t_reset();
    chk("R9 ack idle", {31'b0, rd_ack}, 32'h0);
    rd(1, "R8 empty after power-on");
  endtask

  task automatic t_basic();
    branch(28'h0001000, 28'h0002340);
    rd(0, "R3 source word");
    rd(0, "R3 source read keeps entry");
    rd(1, "R2 destination word");
    rd(1, "R5 consumed entry gone");
  endtask

  task automatic t_order();
    branch(28'hA000010, 28'hB000020);
    branch(28'hA000030, 28'hB000040);
    branch(28'hA000050, 28'hB000060);
    for (int i = 0; i < 3; i++) begin
      rd(0, "R1 newest source first");
      rd(1, "R5 next older after consume");
    end
    rd(1, "R9 drained reads zero");
  endtask

  task automatic t_fetch_in_strobe();
    cyc(1, 28'h0C00000, 0, 0, 0);
    cyc(1, 28'h0C00004, 1, 0, 0);
    cyc(0, '0, 0, 0, 0);
    cyc(1, 28'h0D00000, 0, 0, 0);
    cyc(1, 28'h0D00004, 0, 0, 0);
    m_push(28'h0C00004, 28'h0D00000);
    rd(0, "R4 strobe-cycle fetch is source");
    rd(1, "R4 first later fetch is destination");
    rd(1, "R4 single entry only");
  endtask

  task automatic t_restart();
    cyc(1, 28'h1110000, 0, 0, 0);
    cyc(0, '0, 1, 0, 0);
    cyc(1, 28'h2220000, 1, 0, 0);
    cyc(1, 28'h3330000, 0, 0, 0);
    m_push(28'h2220000, 28'h3330000);
    rd(0, "R10 restarted source");
    rd(1, "R10 restarted destination");
    rd(1, "R10 waiting capture discarded");
  endtask

  task automatic t_collide();
    logic [31:0] exp;
    int k;
    branch(28'h4440000, 28'h5550000);
    cyc(1, 28'h6660000, 0, 0, 0);
    cyc(0, '0, 1, 0, 0);
    exp = m_word(1);
    k = m_top();
    @(negedge clk);
    fetch_valid = 1; fetch_addr = 28'h7770000; rd_en = 1; rd_sel = 1;
    @(posedge clk);
    #1;
    chk("R6 read returns pre-insert entry", rd_data, exp);
    @(negedge clk);
    fetch_valid = 0; rd_en = 0;
    m_v[k] = 0;
    m_push(28'h6660000, 28'h7770000);
    rd(1, "R6 new entry kept valid");
    rd(1, "R6 older entry consumed");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 9; i++)
      branch(28'h8000000 + 28'(i * 16), 28'h9000000 + 28'(i * 16));
    for (int i = 0; i < 8; i++) rd(1, "R7 newest eight kept");
    rd(1, "R7 oldest dropped");
  endtask

  task automatic t_mrst();
    branch(28'h0A0A000, 28'h0B0B000);
    branch(28'h0A0A100, 28'h0B0B100);
    cyc(1, 28'h0E0E000, 0, 0, 0);
    cyc(0, '0, 1, 0, 0);
    @(negedge clk); mrst = 1;
    @(negedge clk); mrst = 0;
    cyc(1, 28'h0F0F000, 0, 0, 0);
    m_clear();
    rd(1, "R8 manual reset clears flags and waiting capture");
  endtask

  task automatic t_por();
    branch(28'h0123000, 28'h0456000);
    @(negedge clk); rst_n = 0;
    #3;
    chk("R8 async clear of ack", {31'b0, rd_ack}, 32'h0);
    @(negedge clk); rst_n = 1;
    m_clear();
    rd(0, "R8 power-on reset clears flags");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_fetch_in_strobe();
    t_restart();
    t_collide();
    t_overflow();
    t_mrst();
    t_por();
    finish_run();
  end
endmodule